// File: doc/BRIEF.md
# Counter Race Frequency Comparator

This block tells whether an oscillator under test runs faster or slower than a reference clock when the two are very close in frequency. On an accepted start, a counter in the reference domain and a counter in the oscillator domain both restart from zero. Each runs to a common terminal count `N` and then holds there. The block reports the oscillator as slow when the reference counter arrives first, and as fast when the oscillator counter arrives first.

The start command enters the oscillator domain as a toggle through a two-flop synchroniser. Completion of the oscillator counter comes back the same way, also as a toggle, and is compared in the reference domain. The result and a one-cycle `done` strobe are both registered on the reference clock. `N` sets the resolution. It must be large enough that, at the smallest frequency offset of interest, one counter leads the other by more cycles than the synchroniser latency and start skew can absorb.

Start uses a valid/ready handshake. A start is taken on a reference edge where `start_valid` and `start_ready` are both high. `start_ready` stays low while a race is in progress. If the reference counter won, it also stays low until the oscillator's late completion has come back through the synchroniser. A `start_valid` seen while `start_ready` is low is dropped and is not held over. Result and done are plain outputs and have no back-pressure.

Top module: `race_cmp`

## Requirements
- R1: During and right after reset, `done` is 0, `osc_fast` is 0 and `start_ready` is 1.
- R2: A start is accepted on a reference edge with `start_valid` and `start_ready` both 1. `start_ready` is 0 from the following cycle until the race is fully resolved.
- R3: Each counter restarts from zero on a start, counts one per edge of its own clock up to `N`, then holds at `N` and never exceeds it.
- R4: When the reference counter arrives first, `done` is 1 exactly `N`+1 reference cycles after the accepting edge, with `osc_fast` = 0 (oscillator slow).
- R5: When the oscillator completion is seen first, `done` is 1 in fewer than `N`+1 reference cycles after the accepting edge, with `osc_fast` = 1 (oscillator fast).
- R6: `done` is high for exactly one reference cycle per race. `osc_fast` changes only in a cycle where `done` is 1 and holds its value until the next `done`.
- R7: If the reference terminal count and the synchronised oscillator completion arrive in the same cycle, the reference wins and the result is slow (`osc_fast` = 0).
- R8: A `start_valid` while `start_ready` is 0 is ignored. The current race's timing and result are unchanged.
- R9: A late oscillator completion after a slow result does not change `osc_fast`. `start_ready` returns to 1 only after that completion has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| osc_clk | input | 1 | Clock of the oscillator under test |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| start_valid | input | 1 | Request to start a race |
| start_ready | output | 1 | High when a start can be accepted |
| done | output | 1 | One-cycle strobe: a result has been decided |
| osc_fast | output | 1 | 1 = oscillator faster, 0 = oscillator slower; valid from `done` |

## Verification
Two events can fall in the same reference cycle: the reference counter reaching `N`, and the synchronised oscillator completion. The bench drives this case by sweeping the oscillator period in small picosecond steps across the crossover point, where the synchroniser delay offsets the lead of the faster clock. At each step it checks that the outcome is either fast with an early `done`, or slow with `done` at exactly `N`+1. A checker property confirms that a coincidence of the two events always gives slow. Well-separated periods are judged against an exact expected result and timing.

// File: rtl/race_cmp_pkg.sv
package race_cmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RACE  = 2'd1,
    ST_DRAIN = 2'd2
  } race_state_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/race_counter.sv
module race_counter #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          at_end
);
  localparam logic [CW-1:0] LIMIT = CW'(N);

  assign at_end = (count == LIMIT);

  // Resets to the limit so the counter sits idle until the first clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= LIMIT;
    else if (clear)   count <= '0;
    else if (!at_end) count <= count + 1'b1;
  end
endmodule

// File: rtl/race_cmp.sv
module race_cmp
  import race_cmp_pkg::*;
#(
  parameter int unsigned N         = 819456,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic osc_clk,
  input  logic osc_rst_n,
  input  logic start_valid,
  output logic start_ready,
  output logic done,
  output logic osc_fast
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] PRE_LIMIT = CW'(N - 1);

  // ---------------- reference domain ----------------
  race_state_e   state;
  logic          accept;
  logic          start_tgl;
  logic [CW-1:0] ref_cnt;
  logic          ref_at_end;
  logic          ref_osc_s;
  logic          ref_osc_d;
  logic          osc_evt;

  assign start_ready = (state == ST_IDLE);
  assign accept      = start_valid && start_ready;

  race_counter #(.N(N), .CW(CW)) u_ref_cnt (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .clear (accept),
    .count (ref_cnt),
    .at_end(ref_at_end)
  );

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n)  start_tgl <= 1'b0;
    else if (accept) start_tgl <= ~start_tgl;
  end

  // ---------------- oscillator domain ----------------
  logic          osc_start_s;
  logic          osc_start_d;
  logic          osc_start_evt;
  logic [CW-1:0] osc_cnt;
  logic          osc_at_end;
  logic          osc_done_tgl;

  bit_sync #(.STAGES(SYNC_DEPTH)) u_start_sync (
    .clk  (osc_clk),
    .rst_n(osc_rst_n),
    .d    (start_tgl),
    .q    (osc_start_s)
  );

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) osc_start_d <= 1'b0;
    else            osc_start_d <= osc_start_s;
  end

  assign osc_start_evt = osc_start_s ^ osc_start_d;

  race_counter #(.N(N), .CW(CW)) u_osc_cnt (
    .clk   (osc_clk),
    .rst_n (osc_rst_n),
    .clear (osc_start_evt),
    .count (osc_cnt),
    .at_end(osc_at_end)
  );

  // Toggle exactly on the edge where the oscillator counter lands on N.
  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n)
      osc_done_tgl <= 1'b0;
    else if (!osc_start_evt && !osc_at_end && osc_cnt == PRE_LIMIT)
      osc_done_tgl <= ~osc_done_tgl;
  end

  // ---------------- back to reference domain ----------------
  bit_sync #(.STAGES(SYNC_DEPTH)) u_done_sync (
    .clk  (ref_clk),
    .rst_n(ref_rst_n),
    .d    (osc_done_tgl),
    .q    (ref_osc_s)
  );

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) ref_osc_d <= 1'b0;
    else            ref_osc_d <= ref_osc_s;
  end

  assign osc_evt = ref_osc_s ^ ref_osc_d;

  // ---------------- decision ----------------
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      osc_fast <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) state <= ST_RACE;
        end
        ST_RACE: begin
          if (ref_at_end) begin
            // reference has priority on a coincidence
            done     <= 1'b1;
            osc_fast <= 1'b0;
            state    <= osc_evt ? ST_IDLE : ST_DRAIN;
          end else if (osc_evt) begin
            done     <= 1'b1;
            osc_fast <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (osc_evt) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_osc;
  assign unused_osc = osc_at_end;
endmodule

// File: rtl/race_cmp_checker.sv
module race_cmp_checker
  import race_cmp_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = 5
) (
  input logic          ref_clk,
  input logic          ref_rst_n,
  input logic          start_valid,
  input logic          start_ready,
  input logic          done,
  input logic          osc_fast,
  input logic [CW-1:0] ref_cnt,
  input logic          osc_evt,
  input race_state_e   state
);
  a_r1_reset_idle: assert property (@(posedge ref_clk)
    !ref_rst_n |-> (start_ready && !done && !osc_fast));

  a_r2_busy_after_accept: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (start_valid && start_ready) |=> !start_ready);

  a_r3_no_overflow: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_cnt <= CW'(N));

  a_r4_slow_at_limit: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (done && !osc_fast) |-> (ref_cnt == CW'(N)));

  a_r6_done_pulse: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    done |=> !done);

  a_r6_result_hold: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !done |-> $stable(osc_fast));

  a_r7_tie_slow: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (state == ST_RACE && ref_cnt == CW'(N) && osc_evt) |=> (done && !osc_fast));

  a_r8_done_from_race: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    done |-> $past(!start_ready));
endmodule

bind race_cmp race_cmp_checker #(.N(N), .CW(CW)) u_race_cmp_checker (
  .ref_clk    (ref_clk),
  .ref_rst_n  (ref_rst_n),
  .start_valid(start_valid),
  .start_ready(start_ready),
  .done       (done),
  .osc_fast   (osc_fast),
  .ref_cnt    (ref_cnt),
  .osc_evt    (osc_evt),
  .state      (state)
);

// File: tb/test_race_cmp.sv
`timescale 1ns/1ps
module test_race_cmp;
  localparam int unsigned N = 128;
  localparam realtime REF_HALF = 4.0;   // 125 MHz
  localparam int unsigned REF_PS = 8000;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready, done, osc_fast;
  realtime osc_half = 4.0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles_seen;
  logic fast_seen;

  always #(REF_HALF) ref_clk = ~ref_clk;
  always #(osc_half) osc_clk = ~osc_clk;

  race_cmp #(.N(N)) i_race_cmp (
    .ref_clk    (ref_clk),
    .ref_rst_n  (rst_n),
    .osc_clk    (osc_clk),
    .osc_rst_n  (rst_n),
    .start_valid(start_valid),
    .start_ready(start_ready),
    .done       (done),
    .osc_fast   (osc_fast)
  );

  function automatic logic exp_fast(input int unsigned period_ps);
    return period_ps < REF_PS;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Runs one race; pokes start_valid mid-race (R8); returns cycle count and result.
  task automatic race(input int unsigned period_ps);
    osc_half = real'(period_ps) / 2000.0;
    @(negedge ref_clk);
    while (!start_ready) @(negedge ref_clk);
    start_valid = 1'b1;
    @(posedge ref_clk);          // accepting edge
    @(negedge ref_clk);
    start_valid = 1'b0;
    cycles_seen = 0;
    fast_seen   = 1'b0;
    for (int i = 0; i < 4 * N; i++) begin
      start_valid = (i == 3);    // R8: ignored while busy
      @(posedge ref_clk);
      cycles_seen++;
      @(negedge ref_clk);
      if (done) begin
        fast_seen = osc_fast;
        break;
      end
    end
    start_valid = 1'b0;
    check("R6 done seen", int'(done), 1);
    @(negedge ref_clk);
    check("R6 done one cycle", int'(done), 0);
    for (int i = 0; i < 4 * N && !start_ready; i++) begin
      @(negedge ref_clk);
      if (osc_fast != fast_seen) check("R9 result held", int'(osc_fast), int'(fast_seen));
    end
    check("R9 ready returns", int'(start_ready), 1);
    check("R9 result after drain", int'(osc_fast), int'(fast_seen));
  endtask

  task automatic directed(input int unsigned period_ps);
    race(period_ps);
    if (exp_fast(period_ps)) begin
      check("R5 fast result", int'(fast_seen), 1);
      check("R5 early done", int'(cycles_seen < N + 1), 1);
    end else begin
      check("R4 slow result", int'(fast_seen), 0);
      check("R4/R8 done at N+1", cycles_seen, N + 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge ref_clk);
    check("R1 done reset", int'(done), 0);
    check("R1 fast reset", int'(osc_fast), 0);
    check("R1 ready reset", int'(start_ready), 1);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check("R1 ready after reset", int'(start_ready), 1);

    directed(5000);   // R5 clearly fast
    directed(12000);  // R4 clearly slow
    directed(8000);   // equal period: synchroniser delay lets reference win
    directed(7000);
    directed(9000);

    for (int k = 0; k < 10; k++) begin
      int unsigned p;
      if ($urandom % 2) p = 4000 + ($urandom % 3001);
      else              p = 9000 + ($urandom % 5001);
      directed(p);
    end

    // R7: sweep across the crossover, where both events may coincide
    for (int k = 0; k < 12; k++) begin
      int unsigned p = 7500 + k * 30;
      race(p);
      if (fast_seen) check("R7 fast consistent", int'(cycles_seen < N + 1), 1);
      else           check("R7 slow consistent", cycles_seen, N + 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(2_000_000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule